// File: doc/BRIEF.md
# Pad Ownership and Conditioning Bank

This block holds the per-pad control state for a bank of general-purpose pads. Each pad is handed to one of three masters: the pin-mux fabric, the plain GPIO register, or an I/O processor. The block then conditions the signals that pass through it. The output can be inverted, the output can be switched to open-drain drive, and the input can be inverted after it has been synchronized. The GPIO register's level and drive enable come from an initial-state request carried in the same write.

Software configures one pad per write. It presents a packed 32-bit word on `cfg_word` with `cfg_we` high. The word carries a pad number, an ownership type, a function index and option flags. The write replaces every stored option of the addressed pad and touches no other pad. A write the block cannot accept leaves all state alone and raises a one-cycle error pulse.

Top module: `padctl_top`

## Requirements
- R1: Word layout: pad number in bits 31:24, type in 23:16, function index in 15:8, flags in 7:0. A valid write replaces all stored options of that one pad and no other pad changes.
- R2: Type bit 16 is the master bit and bit 17 is the first bit (other type bits are ignored). master=1/first=0 selects the pin-mux fabric, master=1/first=1 the GPIO register, and master=0/first=1 the I/O processor. master=0/first=0 is rejected: the write is ignored and `cfg_err` pulses.
- R3: With the pin-mux type, function index 0 gives the pad to the GPIO register, function index 1 gives it to the I/O processor, and any other index gives it to the pin-mux fabric.
- R4: Flag bit 1 sets the GPIO register to drive high (enable 1, level 1). Otherwise flag bit 0 sets it to drive low (enable 1, level 0). With neither bit set the pad is an input (enable 0, level 0). This state is what a GPIO-owned pad presents.
- R5: Flag bit 3 inverts the owning master's output value before it reaches the pad.
- R6: Flag bit 4 selects open-drain drive. `pad_out` is 0, and `pad_oe` is the master's enable AND NOT the output value after inversion.
- R7: The input passes two synchronizer flops and one output register, so a change on `pad_in` reaches `in_cond` three cycles later. It is XORed with flag bit 2 before that last register.
- R8: A write with a pad number above NUM_PADS-1 (98 by default) is ignored, and `cfg_err` is high for exactly the next cycle.
- R9: After reset every pad is GPIO-owned with all flags clear. `pad_out`, `pad_oe`, `in_cond` and `cfg_err` are all 0.
- R10: `pad_out` and `pad_oe` are registered. They reflect a configuration write or a master input change one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 32 | Packed configuration word |
| cfg_err | output | 1 | One-cycle pulse after a rejected write |
| mux_out | input | NUM_PADS | Pin-mux fabric output value per pad |
| mux_oe | input | NUM_PADS | Pin-mux fabric output enable per pad |
| iop_out | input | NUM_PADS | I/O processor output value per pad |
| iop_oe | input | NUM_PADS | I/O processor output enable per pad |
| pad_in | input | NUM_PADS | Raw pad input |
| pad_out | output | NUM_PADS | Conditioned pad output value |
| pad_oe | output | NUM_PADS | Conditioned pad output enable |
| in_cond | output | NUM_PADS | Synchronized, optionally inverted input |

## Verification
The bench sweeps every owner type against all 32 flag values and all four master value/enable pairs. It does this on the first pad, a middle pad and the last legal pad. This exposes a swapped type decode, an inversion applied after the open-drain choice (which would drive high or release the wrong level), and a priority error between the two initial-level flags. Pad numbers 99 and 255 and the reserved type are written against known state. A decoder that wraps the pad number or accepts the reserved code would change a pad that the bench watches. The input path is sampled one cycle before and at the promised latency, which catches a missing or extra synchronizer stage.

// File: rtl/padctl_pkg.sv
package padctl_pkg;
  typedef enum logic [1:0] {
    OWN_MUX  = 2'd0,
    OWN_GPIO = 2'd1,
    OWN_IOP  = 2'd2
  } own_e;

  typedef struct packed {
    own_e own;
    logic iinv;
    logic oinv;
    logic od;
    logic lvl;
    logic en;
  } padcfg_t;

  localparam int FL_DRV_LO = 0;
  localparam int FL_DRV_HI = 1;
  localparam int FL_IINV   = 2;
  localparam int FL_OINV   = 3;
  localparam int FL_OD     = 4;
  localparam int TY_MASTER = 0;
  localparam int TY_FIRST  = 1;
  localparam logic [7:0] FN_GPIO = 8'd0;
  localparam logic [7:0] FN_IOP  = 8'd1;
endpackage

// File: rtl/padctl_decode.sv
module padctl_decode
  import padctl_pkg::*;
#(
  parameter int NUM_PADS = 99,
  localparam int IDX_W   = $clog2(NUM_PADS)
) (
  input  logic             we,
  input  logic [31:0]      word,
  output logic             upd,
  output logic             bad,
  output logic [IDX_W-1:0] idx,
  output padcfg_t          cfg
);
  localparam int MAX_PAD = NUM_PADS - 1;

  logic [7:0] pnum, typ, fn, fl;
  logic       bad_type, bad_pad;

  assign pnum = word[31:24];
  assign typ  = word[23:16];
  assign fn   = word[15:8];
  assign fl   = word[7:0];

  always_comb begin
    bad_type = 1'b0;
    cfg.own  = OWN_GPIO;
    case ({typ[TY_FIRST], typ[TY_MASTER]})
      2'b01: begin
        if (fn == FN_GPIO)     cfg.own = OWN_GPIO;
        else if (fn == FN_IOP) cfg.own = OWN_IOP;
        else                   cfg.own = OWN_MUX;
      end
      2'b11:   cfg.own = OWN_GPIO;
      2'b10:   cfg.own = OWN_IOP;
      default: bad_type = 1'b1;
    endcase
    cfg.iinv = fl[FL_IINV];
    cfg.oinv = fl[FL_OINV];
    cfg.od   = fl[FL_OD];
    cfg.en   = fl[FL_DRV_HI] | fl[FL_DRV_LO];
    cfg.lvl  = fl[FL_DRV_HI];
  end

  assign bad_pad = pnum > 8'(MAX_PAD);
  assign bad     = bad_pad | bad_type;
  assign upd     = we & ~bad;
  assign idx     = pnum[IDX_W-1:0];
endmodule

// File: rtl/padctl_store.sv
module padctl_store
  import padctl_pkg::*;
#(
  parameter int NUM_PADS = 99,
  localparam int IDX_W   = $clog2(NUM_PADS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd,
  input  logic [IDX_W-1:0]        idx,
  input  padcfg_t                 cfg_in,
  output padcfg_t [NUM_PADS-1:0]  cfg_q
);
  localparam padcfg_t CFG_RST = '{own: OWN_GPIO, iinv: 1'b0, oinv: 1'b0,
                                  od: 1'b0, lvl: 1'b0, en: 1'b0};

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PADS; i++) begin
      if (rst)
        cfg_q[i] <= CFG_RST;
      else if (upd && idx == IDX_W'(i))
        cfg_q[i] <= cfg_in;
    end
  end
endmodule

// File: rtl/padctl_outpath.sv
module padctl_outpath
  import padctl_pkg::*;
#(
  parameter int NUM_PADS = 99
) (
  input  logic                    clk,
  input  logic                    rst,
  input  padcfg_t [NUM_PADS-1:0]  cfg_q,
  input  logic [NUM_PADS-1:0]     mux_out,
  input  logic [NUM_PADS-1:0]     mux_oe,
  input  logic [NUM_PADS-1:0]     iop_out,
  input  logic [NUM_PADS-1:0]     iop_oe,
  output logic [NUM_PADS-1:0]     pad_out,
  output logic [NUM_PADS-1:0]     pad_oe
);
  logic [NUM_PADS-1:0] src_o, src_e, eff, nxt_o, nxt_e;

  always_comb begin
    for (int i = 0; i < NUM_PADS; i++) begin
      case (cfg_q[i].own)
        OWN_MUX: begin src_o[i] = mux_out[i];  src_e[i] = mux_oe[i];  end
        OWN_IOP: begin src_o[i] = iop_out[i];  src_e[i] = iop_oe[i];  end
        default: begin src_o[i] = cfg_q[i].lvl; src_e[i] = cfg_q[i].en; end
      endcase
      eff[i] = src_o[i] ^ cfg_q[i].oinv;
      if (cfg_q[i].od) begin
        nxt_o[i] = 1'b0;
        nxt_e[i] = src_e[i] & ~eff[i];
      end else begin
        nxt_o[i] = eff[i];
        nxt_e[i] = src_e[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= nxt_o;
      pad_oe  <= nxt_e;
    end
  end
endmodule

// File: rtl/padctl_inpath.sv
module padctl_inpath
  import padctl_pkg::*;
#(
  parameter int NUM_PADS    = 99,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  padcfg_t [NUM_PADS-1:0]  cfg_q,
  input  logic [NUM_PADS-1:0]     pad_in,
  output logic [NUM_PADS-1:0]     in_cond
);
  logic [SYNC_STAGES-1:0][NUM_PADS-1:0] sr;
  logic [NUM_PADS-1:0] inv;

  always_comb
    for (int i = 0; i < NUM_PADS; i++) inv[i] = cfg_q[i].iinv;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk)
          if (rst) sr[0] <= '0;
          else     sr[0] <= pad_in;
      end else begin : g_next
        always_ff @(posedge clk)
          if (rst) sr[s] <= '0;
          else     sr[s] <= sr[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk)
    if (rst) in_cond <= '0;
    else     in_cond <= sr[SYNC_STAGES-1] ^ inv;
endmodule

// File: rtl/padctl_top.sv
module padctl_top
  import padctl_pkg::*;
#(
  parameter int NUM_PADS    = 99,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [31:0]         cfg_word,
  output logic                cfg_err,
  input  logic [NUM_PADS-1:0] mux_out,
  input  logic [NUM_PADS-1:0] mux_oe,
  input  logic [NUM_PADS-1:0] iop_out,
  input  logic [NUM_PADS-1:0] iop_oe,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] in_cond
);
  localparam int IDX_W = $clog2(NUM_PADS);

  logic                   upd, bad;
  logic [IDX_W-1:0]       idx;
  padcfg_t                cfg_new;
  padcfg_t [NUM_PADS-1:0] cfg_q;

  padctl_decode #(.NUM_PADS(NUM_PADS)) u_dec (
    .we(cfg_we), .word(cfg_word), .upd(upd), .bad(bad), .idx(idx), .cfg(cfg_new)
  );

  padctl_store #(.NUM_PADS(NUM_PADS)) u_store (
    .clk(clk), .rst(rst), .upd(upd), .idx(idx), .cfg_in(cfg_new), .cfg_q(cfg_q)
  );

  padctl_outpath #(.NUM_PADS(NUM_PADS)) u_out (
    .clk(clk), .rst(rst), .cfg_q(cfg_q),
    .mux_out(mux_out), .mux_oe(mux_oe), .iop_out(iop_out), .iop_oe(iop_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  padctl_inpath #(.NUM_PADS(NUM_PADS), .SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk(clk), .rst(rst), .cfg_q(cfg_q), .pad_in(pad_in), .in_cond(in_cond)
  );

  always_ff @(posedge clk)
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= cfg_we & bad;
endmodule

// File: rtl/padctl_chk.sv
module padctl_chk
  import padctl_pkg::*;
#(
  parameter int NUM_PADS = 99
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cfg_we,
  input logic [31:0]            cfg_word,
  input logic                   cfg_err,
  input logic [NUM_PADS-1:0]    pad_out,
  input logic [NUM_PADS-1:0]    pad_oe,
  input padcfg_t [NUM_PADS-1:0] cfg_q
);
  localparam int MAX_PAD = NUM_PADS - 1;

  logic [NUM_PADS-1:0] od_v;
  logic                bad_pad_wr;

  always_comb
    for (int i = 0; i < NUM_PADS; i++) od_v[i] = cfg_q[i].od;

  assign bad_pad_wr = cfg_we && (cfg_word[31:24] > 8'(MAX_PAD));

  AST_BAD_PAD_ERR: assert property (@(posedge clk) disable iff (rst)
    bad_pad_wr |=> cfg_err); // R8
  AST_BAD_PAD_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    bad_pad_wr |=> $stable(cfg_q)); // R8
  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(cfg_we)); // R2
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_out & $past(od_v)) == '0)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_out == '0 && !cfg_err)); // R9
endmodule

bind padctl_top padctl_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_word(cfg_word),
  .cfg_err(cfg_err), .pad_out(pad_out), .pad_oe(pad_oe), .cfg_q(cfg_q)
);

// File: tb/sim_padctl_top.sv
`timescale 1ns/1ps
module sim_padctl_top;
  localparam int N = 99;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [31:0]  cfg_word = '0;
  logic         cfg_err;
  logic [N-1:0] mux_out = '0, mux_oe = '0, iop_out = '0, iop_oe = '0, pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, in_cond;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  padctl_top #(.NUM_PADS(N)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_word(cfg_word), .cfg_err(cfg_err),
    .mux_out(mux_out), .mux_oe(mux_oe), .iop_out(iop_out), .iop_oe(iop_oe),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .in_cond(in_cond)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write; returns at the negedge after the capturing edge
  task automatic wr(input int pad, input int ty, input int fn, input int fl);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_word = {8'(pad), 8'(ty), 8'(fn), 8'(fl)};
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pads[3] = '{0, 37, 98};
    logic [N-1:0] snap_o, snap_e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 pad_oe", 128'(pad_oe), 128'(0));
    chk("R9 pad_out", 128'(pad_out), 128'(0));
    chk("R9 in_cond", 128'(in_cond), 128'(0));
    chk("R9 cfg_err", 128'(cfg_err), 128'(0));

    // R1..R6, R10 sweep: owner type x flags x master value/enable
    foreach (pads[k]) begin
      for (int ty = 1; ty <= 3; ty++) begin
        for (int fl = 0; fl < 32; fl++) begin
          for (int s = 0; s < 4; s++) begin
            int p;
            bit so, se, eo, ee, eff, lvl, en, od;
            p = pads[k];
            so = s[0]; se = s[1];
            mux_out[p] = so;  mux_oe[p] = se;
            iop_out[p] = ~so; iop_oe[p] = ~se;
            wr(p, ty, 5, fl);
            chk("R2 err low on good write", 128'(cfg_err), 128'(0));
            @(negedge clk);
            lvl = fl[1]; en = fl[1] | fl[0];
            case (ty)
              1: begin eo = so;  ee = se;  end   // pin-mux
              2: begin eo = ~so; ee = ~se; end   // I/O processor
              default: begin eo = lvl; ee = en; end // GPIO register
            endcase
            eff = eo ^ fl[3];
            od = fl[4];
            if (od) begin
              eo = 1'b0; ee = ee & ~eff;
            end else begin
              eo = eff;
            end
            chk("R2 R4 R5 R6 R10 pad_out", 128'(pad_out[p]), 128'(eo));
            chk("R2 R4 R5 R6 R10 pad_oe", 128'(pad_oe[p]), 128'(ee));
            chk("R1 untouched pad", 128'({pad_oe[1], pad_out[1]}), 128'(0));
          end
        end
      end
    end

    // R3 function index redirects under pin-mux type
    mux_out[20] = 1'b0; mux_oe[20] = 1'b0;
    iop_out[20] = 1'b1; iop_oe[20] = 1'b1;
    wr(20, 1, 0, 2);             // fn 0 -> GPIO drive high
    @(negedge clk);
    chk("R3 fn0 gpio", 128'({pad_oe[20], pad_out[20]}), 128'(3));
    wr(20, 1, 1, 0);             // fn 1 -> I/O processor
    @(negedge clk);
    chk("R3 fn1 iop", 128'({pad_oe[20], pad_out[20]}), 128'(3));
    wr(20, 1, 2, 2);             // fn 2 -> pin-mux fabric
    @(negedge clk);
    chk("R3 fn2 mux", 128'({pad_oe[20], pad_out[20]}), 128'(0));

    // R10 master input change reaches pad one cycle later
    @(negedge clk);
    mux_out[20] = 1'b1; mux_oe[20] = 1'b1;
    #1;
    chk("R10 not yet", 128'({pad_oe[20], pad_out[20]}), 128'(0));
    @(negedge clk);
    chk("R10 one cycle", 128'({pad_oe[20], pad_out[20]}), 128'(3));

    // R8 out-of-range pads, R2 reserved type
    wr(98, 3, 0, 2);
    @(negedge clk);
    snap_o = pad_out; snap_e = pad_oe;
    wr(99, 3, 0, 1);
    chk("R8 err pad 99", 128'(cfg_err), 128'(1));
    @(negedge clk);
    chk("R8 err one cycle", 128'(cfg_err), 128'(0));
    chk("R8 no change out", 128'(pad_out), 128'(snap_o));
    chk("R8 no change oe", 128'(pad_oe), 128'(snap_e));
    wr(255, 2, 0, 0);
    chk("R8 err pad 255", 128'(cfg_err), 128'(1));
    @(negedge clk);
    chk("R8 no change 255", 128'({pad_oe, pad_out}), 128'({snap_e, snap_o}));
    wr(98, 0, 0, 1);
    chk("R2 reserved type err", 128'(cfg_err), 128'(1));
    @(negedge clk);
    chk("R2 reserved type ignored", 128'({pad_oe[98], pad_out[98]}), 128'(3));

    // R7 input path latency and inversion
    wr(3, 3, 0, 4);              // pad 3 input inverted
    wr(4, 3, 0, 0);              // pad 4 plain
    repeat (2) @(negedge clk);
    chk("R7 inverted idle", 128'(in_cond[4:3]), 128'(2'b01));
    pad_in[3] = 1'b1; pad_in[4] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 before latency", 128'(in_cond[4:3]), 128'(2'b01));
    @(negedge clk);
    chk("R7 at latency", 128'(in_cond[4:3]), 128'(2'b10));
    pad_in[3] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 falling", 128'(in_cond[3]), 128'(1));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule